// File: doc/BRIEF.md
# Cascadable Prescaled Timer Pair

This block holds two down-counting timers that share one register port. The low timer is 24 bits wide and the high timer is 32 bits wide. Each timer picks one of four tick strobes as its clock. Each strobe is a one-cycle enable that stands in for a 8 MHz, 32.768 kHz, 1.024 kHz or 32 Hz source. Each timer can run on its own. It counts down from a programmed reload value. When an advance finds the count at zero, the timer reloads and raises a terminal-count interrupt.

When the chain bit is set in the low timer's control word, the low timer becomes a prescaler. Every low-timer terminal count advances the high timer by one. The high timer's readback then shows the bitwise complement of its internal count, so it reads as an upward counter. If the low reload value is 7 and the low timer runs from the 8 MHz strobe, the high timer becomes a microsecond counter that software can preset. To preset it to T, write all-ones minus T to the high reload register, then restart the low timer with the chain bit set. When the readback passes all-ones, it wraps to the complement of the reload value and the high interrupt fires.

The register port is a plain single-cycle control port, not a data stream. A write is taken on any clock edge where `wr_en` is high. Reads are combinational from `addr` and there is no back-pressure.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register address reads zero and both interrupt outputs are low.
- R2: An enabled timer whose selected strobe is high moves its count from N to N-1. When the count is 0, the advance reloads the count from the reload register and is a terminal count, so a reload value S gives one terminal count every S+1 advances.
- R3: A terminal count raises that timer's interrupt output for exactly the following clock cycle. It also sets the status bit, bit 4 of that timer's control word, which stays set until a control write with bit 4 = 1 clears it.
- R4: Clock select value 0 picks source strobe 0 (8 MHz), 1 picks strobe 1 (32.768 kHz), 2 picks strobe 2 (1.024 kHz) and 3 picks strobe 3 (32 Hz).
- R5: A control write with bit 1 = 1 loads the count from the reload register on that edge. The restart takes precedence over an advance in the same cycle, and bit 1 always reads back 0. Writing 0x03 enables and restarts in one access.
- R6: While control bit 0 (enable) is 0, the count holds its value and the timer raises no interrupt.
- R7: While bit 3 of the low control word (chain) is 1, the high timer advances once per low terminal count and ignores its own clock select.
- R8: The high count readback is the bitwise complement of the internal count while chain is 1, and the raw count while chain is 0. The low readback is always the raw count.
- R9: A low control write with bit 1 = 1 and bit 3 = 1 also reloads the high count from the high reload register. A high reload of 0xFFFFFFFF therefore makes the readback 0, and a reload of 0xFFFFFFFF-T makes it T.
- R10: In chained mode, the advance after the readback shows 0xFFFFFFFF makes the readback equal to the complement of the high reload value, and the high interrupt fires.
- R11: Register map by address: 0 low control, 1 low clock select, 2 low reload, 3 low count, 4 high control, 5 high clock select, 6 high reload, 7 high count. Writes to 3 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC (4) | One-cycle enable strobes of the selectable clock sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_lo | output | 1 | Low timer terminal-count pulse |
| irq_hi | output | 1 | High timer terminal-count pulse |

## Verification
Counting is tried with three strobe patterns, each separating a different class of fault:
- **Strobes always high.** The period depends only on the reload value, which exposes off-by-one reload errors.
- **Strobes firing at unrelated intervals.** This shows whether the clock select routes the right source.
- **Strobes all low.** This shows that writes and status clears work with no counting in the way.

Chained runs keep the high timer's own selected strobe firing every cycle, so a high timer that fails to ignore it reads a wrong microsecond value. Preset and wrap-around runs check the complemented readback against the exact values expected at the wrap.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LO_CTRL = 3'd0,
    A_LO_SEL  = 3'd1,
    A_LO_SET  = 3'd2,
    A_LO_CNT  = 3'd3,
    A_HI_CTRL = 3'd4,
    A_HI_SEL  = 3'd5,
    A_HI_SET  = 3'd6,
    A_HI_CNT  = 3'd7
  } reg_addr_e;

  // control word bit positions
  localparam int B_EN  = 0;
  localparam int B_RST = 1;
  localparam int B_CHN = 3;
  localparam int B_STS = 4;
endpackage

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
  parameter int NSRC = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) tick = src_tick[i];
    end
  end
endmodule

// File: rtl/tmr_down_ctr.sv
module tmr_down_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic             restart,
  input  logic [CNT_W-1:0] set_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign tc      = en & adv & ~restart & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= set_val;
    else if (en & adv) cnt <= at_zero ? set_val : cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 24,
  parameter int NSRC  = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             wr_ctrl,
  input  logic             wr_sel,
  input  logic             wr_set,
  input  logic             en_wdata,
  input  logic             sts_clr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [CNT_W-1:0] set_wdata,
  input  logic             restart,
  input  logic             use_ext,
  input  logic             ext_adv,
  output logic             en,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] set_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tc,
  output logic             irq,
  output logic             sts
);
  logic own_tick;
  logic adv;

  tmr_src_mux #(.NSRC(NSRC)) u_mux (
    .src_tick (src_tick),
    .sel      (sel),
    .tick     (own_tick)
  );

  assign adv = use_ext ? ext_adv : own_tick;

  tmr_down_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .adv     (adv),
    .restart (restart),
    .set_val (set_val),
    .cnt     (cnt),
    .tc      (tc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      sel     <= '0;
      set_val <= '0;
      irq     <= 1'b0;
      sts     <= 1'b0;
    end else begin
      if (wr_ctrl) en      <= en_wdata;
      if (wr_sel)  sel     <= sel_wdata;
      if (wr_set)  set_val <= set_wdata;
      irq <= tc;
      sts <= tc | (sts & ~(wr_ctrl & sts_clr));
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int LO_W   = 24,
  parameter int HI_W   = 32,
  parameter int NSRC   = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(addr);

  logic wr_lo_ctrl, wr_lo_sel, wr_lo_set;
  logic wr_hi_ctrl, wr_hi_sel, wr_hi_set;
  assign wr_lo_ctrl = wr_en & (ra == A_LO_CTRL);
  assign wr_lo_sel  = wr_en & (ra == A_LO_SEL);
  assign wr_lo_set  = wr_en & (ra == A_LO_SET);
  assign wr_hi_ctrl = wr_en & (ra == A_HI_CTRL);
  assign wr_hi_sel  = wr_en & (ra == A_HI_SEL);
  assign wr_hi_set  = wr_en & (ra == A_HI_SET);

  logic chained;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chained <= 1'b0;
    else if (wr_lo_ctrl) chained <= wdata[B_CHN];
  end

  logic lo_restart, hi_restart;
  assign lo_restart = wr_lo_ctrl & wdata[B_RST];
  assign hi_restart = (wr_hi_ctrl & wdata[B_RST]) | (lo_restart & wdata[B_CHN]);

  logic             lo_en, hi_en, lo_tc, hi_tc, lo_sts, hi_sts;
  logic [SEL_W-1:0] lo_sel, hi_sel;
  logic [LO_W-1:0]  lo_set, lo_cnt;
  logic [HI_W-1:0]  hi_set, hi_cnt;

  tmr_chan #(.CNT_W(LO_W), .NSRC(NSRC)) u_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .wr_ctrl   (wr_lo_ctrl),
    .wr_sel    (wr_lo_sel),
    .wr_set    (wr_lo_set),
    .en_wdata  (wdata[B_EN]),
    .sts_clr   (wdata[B_STS]),
    .sel_wdata (wdata[SEL_W-1:0]),
    .set_wdata (wdata[LO_W-1:0]),
    .restart   (lo_restart),
    .use_ext   (1'b0),
    .ext_adv   (1'b0),
    .en        (lo_en),
    .sel       (lo_sel),
    .set_val   (lo_set),
    .cnt       (lo_cnt),
    .tc        (lo_tc),
    .irq       (irq_lo),
    .sts       (lo_sts)
  );

  tmr_chan #(.CNT_W(HI_W), .NSRC(NSRC)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .wr_ctrl   (wr_hi_ctrl),
    .wr_sel    (wr_hi_sel),
    .wr_set    (wr_hi_set),
    .en_wdata  (wdata[B_EN]),
    .sts_clr   (wdata[B_STS]),
    .sel_wdata (wdata[SEL_W-1:0]),
    .set_wdata (wdata[HI_W-1:0]),
    .restart   (hi_restart),
    .use_ext   (chained),
    .ext_adv   (lo_tc),
    .en        (hi_en),
    .sel       (hi_sel),
    .set_val   (hi_set),
    .cnt       (hi_cnt),
    .tc        (hi_tc),
    .irq       (irq_hi),
    .sts       (hi_sts)
  );

  logic [HI_W-1:0] hi_view;
  assign hi_view = chained ? ~hi_cnt : hi_cnt;

  always_comb begin
    rdata = '0;
    unique case (ra)
      A_LO_CTRL: begin
        rdata[B_EN]  = lo_en;
        rdata[B_CHN] = chained;
        rdata[B_STS] = lo_sts;
      end
      A_LO_SEL:  rdata = DATA_W'(lo_sel);
      A_LO_SET:  rdata = DATA_W'(lo_set);
      A_LO_CNT:  rdata = DATA_W'(lo_cnt);
      A_HI_CTRL: begin
        rdata[B_EN]  = hi_en;
        rdata[B_STS] = hi_sts;
      end
      A_HI_SEL:  rdata = DATA_W'(hi_sel);
      A_HI_SET:  rdata = DATA_W'(hi_set);
      A_HI_CNT:  rdata = DATA_W'(hi_view);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int LO_W = 24,
  parameter int HI_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chained,
  input logic            lo_en,
  input logic            lo_tc,
  input logic            hi_tc,
  input logic            lo_restart,
  input logic            hi_restart,
  input logic [LO_W-1:0] lo_cnt,
  input logic [LO_W-1:0] lo_set,
  input logic [HI_W-1:0] hi_cnt,
  input logic [HI_W-1:0] hi_set,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic            lo_sts,
  input logic            hi_sts
);
  // R3
  lo_irq_follows_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_tc |=> irq_lo);
  // R3
  lo_irq_only_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_tc |=> !irq_lo);
  // R3
  hi_irq_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> hi_sts);
  // R3
  lo_irq_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> lo_sts);
  // R5
  lo_restart_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_restart |=> (lo_cnt == $past(lo_set)));
  // R6
  lo_frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_en && !lo_restart) |=> $stable(lo_cnt));
  // R6
  lo_no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_en |=> !irq_lo);
  // R7
  hi_steps_only_on_lo_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && !lo_tc && !hi_restart) |=> $stable(hi_cnt));
  // R10
  hi_wrap_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_tc |=> (hi_cnt == $past(hi_set)));
endmodule

bind tmr_pair tmr_pair_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chained    (chained),
  .lo_en      (lo_en),
  .lo_tc      (lo_tc),
  .hi_tc      (hi_tc),
  .lo_restart (lo_restart),
  .hi_restart (hi_restart),
  .lo_cnt     (lo_cnt),
  .lo_set     (lo_set),
  .hi_cnt     (hi_cnt),
  .hi_set     (hi_set),
  .irq_lo     (irq_lo),
  .irq_hi     (irq_hi),
  .lo_sts     (lo_sts),
  .hi_sts     (hi_sts)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = 4'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  always #10 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int    cmp_n = 0, cmp_f = 0, dir_n = 0, dir_f = 0;
  int    n_irq_lo = 0, n_irq_hi = 0;
  int    tick_mode = 1;  // 0 pattern, 1 all high, 2 all low
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // strobe generator, drives away from the edge
  always @(posedge clk) begin
    #5;
    cyc = cyc + 1;
    case (tick_mode)
      0: src_tick = {cyc % 11 == 0, cyc % 7 == 0, cyc % 5 == 0, cyc % 2 == 0};
      1: src_tick = 4'hF;
      default: src_tick = 4'h0;
    endcase
  end

  // behavioural reference model
  logic        m_lo_en, m_hi_en, m_chn, m_irq_lo, m_irq_hi, m_sts_lo, m_sts_hi;
  logic [1:0]  m_lo_sel, m_hi_sel;
  logic [23:0] m_lo_set, m_lo;
  logic [31:0] m_hi_set, m_hi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo_en = 0; m_hi_en = 0; m_chn = 0; m_irq_lo = 0; m_irq_hi = 0;
      m_sts_lo = 0; m_sts_hi = 0; m_lo_sel = 0; m_hi_sel = 0;
      m_lo_set = 0; m_lo = 0; m_hi_set = 0; m_hi = 0;
    end else begin
      bit lo_go, hi_go, lo_rs, hi_rs, lo_hit, hi_hit;
      lo_rs  = wr_en && addr == 0 && wdata[1];
      hi_rs  = (wr_en && addr == 4 && wdata[1]) || (lo_rs && wdata[3]);
      lo_go  = m_lo_en && src_tick[m_lo_sel] && !lo_rs;
      lo_hit = lo_go && m_lo == 0;
      hi_go  = m_hi_en && (m_chn ? lo_hit : src_tick[m_hi_sel]) && !hi_rs;
      hi_hit = hi_go && m_hi == 0;
      if (lo_rs) m_lo = m_lo_set;
      else if (lo_go) m_lo = lo_hit ? m_lo_set : m_lo - 1;
      if (hi_rs) m_hi = m_hi_set;
      else if (hi_go) m_hi = hi_hit ? m_hi_set : m_hi - 1;
      m_irq_lo = lo_hit;
      m_irq_hi = hi_hit;
      if (wr_en && addr == 0 && wdata[4]) m_sts_lo = 0;
      if (wr_en && addr == 4 && wdata[4]) m_sts_hi = 0;
      if (lo_hit) m_sts_lo = 1;
      if (hi_hit) m_sts_hi = 1;
      if (wr_en) begin
        case (addr)
          0: begin m_lo_en = wdata[0]; m_chn = wdata[3]; end
          1: m_lo_sel = wdata[1:0];
          2: m_lo_set = wdata[23:0];
          4: m_hi_en = wdata[0];
          5: m_hi_sel = wdata[1:0];
          6: m_hi_set = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_sts_lo, m_chn, 2'b00, m_lo_en};
      3'd1: return {30'd0, m_lo_sel};
      3'd2: return {8'd0, m_lo_set};
      3'd3: return {8'd0, m_lo};
      3'd4: return {27'd0, m_sts_hi, 1'b0, 2'b00, m_hi_en};
      3'd5: return {30'd0, m_hi_sel};
      3'd6: return m_hi_set;
      default: return m_chn ? ~m_hi : m_hi;
    endcase
  endfunction

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_lo) n_irq_lo = n_irq_lo + 1;
      if (irq_hi) n_irq_hi = n_irq_hi + 1;
      cmp_n = cmp_n + 1;
      if (irq_lo !== m_irq_lo || irq_hi !== m_irq_hi || rdata !== model_rd(addr)) begin
        cmp_f = cmp_f + 1;
        $display("FAIL %s cycle %0d: irq_lo=%b irq_hi=%b rdata[%0d]=%h expected %b %b %h",
                 cur_tag, cyc, irq_lo, irq_hi, addr, rdata, m_irq_lo, m_irq_hi, model_rd(addr));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #5;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    dir_n = dir_n + 1;
    if (rdata !== exp) begin
      dir_f = dir_f + 1;
      $display("FAIL %s: addr %0d read %h expected %h", tag, a, rdata, exp);
    end
    @(posedge clk); #5;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
    @(posedge clk); #5;
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    dir_n = dir_n + 1;
    if (act != exp) begin
      dir_f = dir_f + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 R11: every address zero after reset
    cur_tag = "R1";
    for (int a = 0; a < 8; a++) chk(3'(a), 32'd0, "R1");
    chk_int(int'(irq_lo) + int'(irq_hi), 0, "R1");

    // R2 standalone low timer, reload 5, strobe always high
    cur_tag = "R2";
    wr(3'd2, 32'd5); wr(3'd1, 32'd0); wr(3'd0, 32'h03);
    chk(3'd3, 32'd5, "R5");
    base = n_irq_lo; idle(60);
    chk_int(n_irq_lo - base, 10, "R2");
    chk(3'd0, 32'h11, "R3");
    wr(3'd3, 32'h123);  // write to count address ignored (R11)

    // R3 write-one-to-clear with strobes stopped
    cur_tag = "R3";
    tick_mode = 2; idle(1);
    wr(3'd0, 32'h11);
    chk(3'd0, 32'h01, "R3");

    // R6 disable freezes and silences
    cur_tag = "R6";
    wr(3'd0, 32'h00); tick_mode = 1;
    rd(3'd3, v);
    base = n_irq_lo; idle(30);
    chk(3'd3, v, "R6");
    chk_int(n_irq_lo - base, 0, "R6");

    // R4 clock select 2 with irregular strobes: period 3 advances of 7 cycles
    cur_tag = "R4";
    tick_mode = 0;
    wr(3'd2, 32'd2); wr(3'd1, 32'd2); wr(3'd0, 32'h03);
    base = n_irq_lo; idle(210);
    chk_int(n_irq_lo - base, 10, "R4");
    wr(3'd6, 32'd1); wr(3'd5, 32'd3); wr(3'd4, 32'h03);
    idle(100);
    wr(3'd0, 32'h00);

    // R7 R8 chained microsecond counter, high select left on a live strobe
    cur_tag = "R7";
    tick_mode = 1;
    wr(3'd5, 32'd3); wr(3'd6, 32'hFFFF_FFFF); wr(3'd4, 32'h01);
    wr(3'd2, 32'd7); wr(3'd1, 32'd0); wr(3'd0, 32'h0B);
    chk(3'd7, 32'd0, "R8");
    idle(79);
    chk(3'd7, 32'd10, "R7");

    // R9 preset
    cur_tag = "R9";
    wr(3'd6, 32'hFFFF_FFFF - 32'd1000); wr(3'd0, 32'h0B);
    chk(3'd7, 32'd1000, "R9");
    idle(15);
    chk(3'd7, 32'd1002, "R9");

    // R10 wrap of the readback
    cur_tag = "R10";
    wr(3'd6, 32'd2); wr(3'd0, 32'h0B);
    base = n_irq_hi; idle(40);
    chk(3'd7, 32'hFFFF_FFFF, "R10");
    chk_int(n_irq_hi - base, 1, "R10");
    chk(3'd4, 32'h11, "R10");

    // R8 raw readback once chain is cleared
    cur_tag = "R8";
    tick_mode = 2; idle(1);
    rd(3'd7, v);
    wr(3'd0, 32'h00);
    chk(3'd7, ~v, "R8");
    idle(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", (cmp_n + dir_n) - (cmp_f + dir_f), cmp_n + dir_n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", (cmp_n + dir_n) - (cmp_f + dir_f), cmp_n + dir_n + 1);
      $finish;
    end
  end
endmodule